// File: doc/BRIEF.md
# Transition-Indexed Switching Energy Estimator

This block estimates the dynamic energy spent by a monitored hardware block, using the activity that block actually sees. Once per clock, when a valid sample is present, it pairs the previous input vector with the current one. It uses that pair to look up a switched capacitance in a programmable table. The capacitance is multiplied by a programmable constant that stands for the squared supply voltage, and the product is added to a running energy total. Frequency is treated as fixed, so the total per sample is a per-cycle energy sum. Because the table is indexed by transitions rather than by values, the estimate depends on the order of the applied stimulus.

Characterization values are loaded through a simple table write port. The total can be read at any time and cleared synchronously. All arithmetic is unsigned integer or fixed point, and the interpretation of the scaling is left to the user.

Top module: `trans_energy_meter`

## Requirements
- R1: After reset the energy output is zero, the previous-vector register holds all zeros, and every table entry holds zero.
- R2: The first valid sample after reset adds no energy, whatever the table holds; it only records its vector as the previous vector.
- R3: The table index is the previous vector in the upper VEC_W bits joined with the current vector in the lower VEC_W bits, so a transition A to B reads entry {A,B} and not entry {B,A}.
- R4: Every later valid sample adds table[{prev,cur}] times vsq_k to the accumulator, and the new total is visible on energy_out right after the clock edge that takes the sample.
- R5: A cycle with smp_valid low changes neither the accumulator nor the previous vector, whatever smp_vec carries.
- R6: When a table write and a sample occur in the same cycle, the sample uses the entry's old value, and the written value applies from the next cycle on.
- R7: The accumulator saturates at its all-ones value instead of wrapping, and stays there until cleared.
- R8: energy_clr zeroes the accumulator on the next edge, overrides a sample in the same cycle (whose energy is dropped), and leaves the table and the previous-vector tracking intact.
- R9: The vsq_k value present in the sampling cycle scales that sample's energy; a change applies from the next sample on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Qualifies smp_vec in this cycle |
| smp_vec | input | VEC_W | Observed input vector of the monitored block |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 2*VEC_W | Table entry to write, {prev,cur} |
| tbl_cap | input | CAP_W | Switched capacitance to store |
| vsq_k | input | VSQ_W | Supply-squared scale factor |
| energy_clr | input | 1 | Synchronous clear of the accumulator |
| energy_out | output | ACC_W | Accumulated energy |

## Verification
The bench builds the block with a 3-bit vector, so the table has 64 entries, and with 12-bit capacitance and scale values. The accumulator is reduced from 48 to 30 bits. With full-scale entries, each toggling sample then adds close to 2^24, so saturation is reached after roughly 64 samples instead of millions. Swapping the order of a transition, writing and sampling in the same cycle, and clearing during a sample are all exercised against a reference model of the table.

// File: rtl/trans_energy_meter.sv
module trans_energy_meter #(
  parameter int VEC_W = 3,
  parameter int CAP_W = 12,
  parameter int VSQ_W = 12,
  parameter int ACC_W = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  input  logic [VEC_W-1:0]   smp_vec,
  input  logic               tbl_we,
  input  logic [2*VEC_W-1:0] tbl_addr,
  input  logic [CAP_W-1:0]   tbl_cap,
  input  logic [VSQ_W-1:0]   vsq_k,
  input  logic               energy_clr,
  output logic [ACC_W-1:0]   energy_out
);
  localparam int IDX_W  = 2 * VEC_W;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int PROD_W = CAP_W + VSQ_W;

  logic [CAP_W-1:0]  cap_tbl [DEPTH];
  logic [VEC_W-1:0]  prev_q;
  logic              armed_q;
  logic [ACC_W-1:0]  acc_q;
  logic [IDX_W-1:0]  rd_idx;
  logic [PROD_W-1:0] step_e;
  logic [ACC_W:0]    sum_w;

  assign rd_idx     = {prev_q, smp_vec};
  assign step_e     = armed_q ? PROD_W'(cap_tbl[rd_idx]) * PROD_W'(vsq_k) : '0;
  assign sum_w      = {1'b0, acc_q} + {{(ACC_W+1-PROD_W){1'b0}}, step_e};
  assign energy_out = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cap_tbl[i] <= '0;
    end else if (tbl_we) begin
      cap_tbl[tbl_addr] <= tbl_cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else if (smp_valid) begin
      prev_q  <= smp_vec;
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            acc_q <= '0;
    else if (energy_clr)   acc_q <= '0;
    else if (smp_valid)    acc_q <= sum_w[ACC_W] ? '1 : sum_w[ACC_W-1:0];
  end

  // R8
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    energy_clr |=> energy_out == '0);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !energy_clr) |=> $stable(energy_out));

  // R2
  first_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && smp_valid && !energy_clr) |=> $stable(energy_out));

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !energy_clr |=> energy_out >= $past(energy_out));

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (energy_out == '1 && !energy_clr) |=> energy_out == '1);
endmodule

// File: tb/trans_energy_meter_tb.sv
module trans_energy_meter_tb;
  localparam int VEC_W = 3;
  localparam int CAP_W = 12;
  localparam int VSQ_W = 12;
  localparam int ACC_W = 30;
  localparam int IDX_W = 2 * VEC_W;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, tbl_we = 0, energy_clr = 0;
  logic [VEC_W-1:0] smp_vec = '0;
  logic [IDX_W-1:0] tbl_addr = '0;
  logic [CAP_W-1:0] tbl_cap = '0;
  logic [VSQ_W-1:0] vsq_k = '0;
  logic [ACC_W-1:0] energy_out;

  always #2.5 clk = ~clk;

  trans_energy_meter #(.VEC_W(VEC_W), .CAP_W(CAP_W), .VSQ_W(VSQ_W), .ACC_W(ACC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_vec(smp_vec),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_cap(tbl_cap), .vsq_k(vsq_k),
    .energy_clr(energy_clr), .energy_out(energy_out));

  int checks = 0, fails = 0;
  logic [ACC_W-1:0] exp_q[$];
  string tag_q[$];

  logic [CAP_W-1:0] m_tab [1<<IDX_W];
  logic [VEC_W-1:0] m_prev;
  logic m_armed;
  logic [ACC_W-1:0] m_acc;

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [ACC_W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (energy_out !== e) begin
        fails++;
        $display("FAIL %s: energy_out=%0d expected=%0d", t, energy_out, e);
      end
    end
  end

  task automatic step(input logic v, input logic [VEC_W-1:0] vec, input logic we,
                      input logic [IDX_W-1:0] wa, input logic [CAP_W-1:0] wd,
                      input logic clr, input string tag);
    logic [ACC_W:0] sum;
    logic [ACC_W-1:0] e;
    smp_valid = v; smp_vec = vec; tbl_we = we; tbl_addr = wa; tbl_cap = wd; energy_clr = clr;
    @(posedge clk);
    e = m_armed ? ACC_W'(m_tab[{m_prev, vec}]) * ACC_W'(vsq_k) : '0;
    sum = {1'b0, m_acc} + {1'b0, e};
    if (clr) m_acc = '0;
    else if (v) m_acc = sum[ACC_W] ? '1 : sum[ACC_W-1:0];
    if (v) begin m_prev = vec; m_armed = 1'b1; end
    if (we) m_tab[wa] = wd;
    exp_q.push_back(m_acc);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic smp(input logic [VEC_W-1:0] vec, input string tag);
    step(1'b1, vec, 1'b0, '0, '0, 1'b0, tag);
  endtask

  task automatic wr(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                    input logic [CAP_W-1:0] d, input string tag);
    step(1'b0, 3'd7, 1'b1, {a, b}, d, 1'b0, tag);
  endtask

  bit done = 0;

  initial begin
    for (int i = 0; i < (1 << IDX_W); i++) m_tab[i] = '0;
    m_prev = '0; m_armed = 0; m_acc = '0;
    vsq_k = 12'd3;
    repeat (3) @(negedge clk);
    checks++;
    if (energy_out !== '0) begin fails++; $display("FAIL R1: energy_out=%0d expected=0", energy_out); end
    rst_n = 1;
    @(negedge clk);
    step(1'b0, 3'd5, 1'b0, '0, '0, 1'b0, "R5 idle after reset");
    // R2: entry {0,4} loaded, yet the first sample adds nothing
    wr(3'd0, 3'd4, 12'd9, "R1 write only");
    smp(3'd4, "R2 first sample");
    smp(3'd5, "R1 empty entry reads zero");
    wr(3'd5, 3'd6, 12'd10, "R5 write only");
    wr(3'd6, 3'd1, 12'd7, "R5 write only");
    wr(3'd1, 3'd1, 12'd100, "R5 write only");
    smp(3'd6, "R4 5->6 adds 30");
    smp(3'd1, "R3 6->1 adds 21");
    smp(3'd1, "R4 1->1 adds 300");
    smp(3'd6, "R3 1->6 reversed entry is zero");
    step(1'b0, 3'd2, 1'b0, '0, '0, 1'b0, "R5 invalid vector ignored");
    smp(3'd1, "R5 prev kept across idle, 6->1");
    smp(3'd6, "R3 1->6");
    // R6: write {6,3} while sampling 3 from prev 6
    step(1'b1, 3'd3, 1'b1, {3'd6, 3'd3}, 12'd50, 1'b0, "R6 same-cycle write uses old entry");
    smp(3'd6, "R6 3->6");
    smp(3'd3, "R6 new entry now applies");
    vsq_k = 12'd5;
    smp(3'd6, "R9 3->6 zero");
    smp(3'd3, "R9 new scale applies");
    step(1'b1, 3'd6, 1'b0, '0, '0, 1'b1, "R8 clear overrides sample");
    smp(3'd1, "R8 table and prev kept after clear");
    step(1'b0, 3'd0, 1'b0, '0, '0, 1'b1, "R8 plain clear");
    vsq_k = 12'hFFF;
    wr(3'd0, 3'd7, 12'hFFF, "R7 load full entry");
    wr(3'd7, 3'd0, 12'hFFF, "R7 load full entry");
    smp(3'd0, "R7 1->0 zero");
    for (int k = 0; k < 80; k++) smp((k % 2 == 0) ? 3'd7 : 3'd0, "R7 saturation");
    step(1'b0, 3'd0, 1'b0, '0, '0, 1'b1, "R8 clear from saturation");
    smp(3'd7, "R4 after clear");
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule